// File: doc/BRIEF.md
# Concurrent Distance Counter Pool

This block runs a pool of ten counters so that several distance windows can be measured at the same time. Each new error event claims the next counter in rotating order. That counter then counts rising edges of an encoder pulse input until it reaches a distance target supplied on an input port. When it reaches the target, the counter frees itself. A gate-enable output stays high while any counter in the pool is running.

Both asynchronous inputs pass through two-flop synchronizers and are edge-detected in the system clock domain. An error event can arrive while the counter it would claim is still running. In that case the event is refused: a sticky overflow flag is raised and the running window is left alone.

Top module: `dist_counter_pool`

## Requirements
- R1: The pool holds ten counters that run independently, so that windows started by different error events can overlap in time and each one ends on its own count.
- R2: A counter is started only by a rising edge of `err_in`. Holding `err_in` high starts exactly one counter. After `err_in` goes high, `gate_en` first reads high following the third rising clock edge (two synchronizer stages plus the start register).
- R3: A running counter adds one for each rising edge of `enc_in` and holds its value otherwise. Encoder edges seen while no counter is running change nothing.
- R4: A running counter stops at the first clock edge at which its count already equals `dist_target`. With an `enc_in` rise seen before edge k, that is edge k+3 for the pulse that reaches the target. A target of 0 keeps the counter running for a single cycle.
- R5: Counters are claimed in rotating order 0, 1, …, 9, 0, and so on. A counter that has stopped can be claimed again when the rotation reaches it.
- R6: An error edge that finds its counter still running sets `overflow`. That counter is not restarted and the rotation does not advance. `overflow` then stays at 1 until reset.
- R7: `gate_en` is 1 exactly while at least one counter is running.
- R8: A synchronous active-low reset stops all counters, clears the rotation index and clears `overflow`. After it, `gate_en` and `overflow` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_in | input | 1 | Error event input, asynchronous; a rising edge claims a counter |
| enc_in | input | 1 | Encoder pulse input, asynchronous; rising edges advance running counters |
| dist_target | input | 16 | Distance count at which a running counter stops |
| gate_en | output | 1 | High while any counter is running |
| overflow | output | 1 | Sticky flag: an error edge found its counter still running |

## Verification
The hardest situation to reach from the ports is a full pool in which windows end at different counts, followed by a refused event and then reuse after the rotation wraps. Nothing inside the pool is visible from outside, so the stimulus works through `gate_en` and `overflow`. It starts counters with pulses spread between encoder edges, so their counts are staggered. It fills all ten slots and sends an eleventh event. It drains the pool and refills it, and checks that the refill is accepted. A held-high error level and encoder edges with no counter running confirm that only edges matter.

// File: rtl/dcp_pkg.sv
// Shared helpers for the distance counter pool.
// Assumes nothing beyond integer arithmetic.
package dcp_pkg;

    // Rotating successor of an index within a ring of the given size.
    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned size);
        return (cur >= size - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/dcp_edge_sync.sv
// Synchronizes an asynchronous level into the clock domain and emits a
// one-cycle pulse on each rising edge of the synchronized level.
// Assumes the input stays stable for at least one clock period per level.
module dcp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    // Shift the level through the synchronizer chain and keep its last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    // The pulse is high in the first cycle in which the synchronized level reads high.
    always_comb rise_o = shift_q[STAGES-1] & ~prev_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R2
endmodule

// File: rtl/dcp_slot.sv
// One distance counter. It is started (cleared, marked running) by start_i,
// counts encoder pulses while running, and stops at the edge after its count
// matches the target. Assumes start_i is only raised while the slot is idle.
module dcp_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             enc_pulse_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             busy_o
);
    logic [CNT_W-1:0] cnt_q;

    // Start, count or stop the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_o) begin
            if (cnt_q == target_i)
                busy_o <= 1'b0;
            else if (enc_pulse_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_STOP_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(cnt_q == target_i)); // R4
    AST_HOLD_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !enc_pulse_i && !start_i) |=> $stable(cnt_q)); // R3
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R6
endmodule

// File: rtl/dist_counter_pool.sv
// Pool of concurrent distance counters. Each synchronized error edge claims
// the next slot in rotating order. Slots count synchronized encoder edges
// up to dist_target and then free themselves. gate_en is high while any slot
// runs. overflow sticks when an error edge finds its slot busy.
// Assumes err_in and enc_in are asynchronous levels wider than one clock.
module dist_counter_pool #(
    parameter int NUM_CTR     = 10,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_in,
    input  logic             enc_in,
    input  logic [CNT_W-1:0] dist_target,
    output logic             gate_en,
    output logic             overflow
);
    localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    logic               err_rise;
    logic               enc_rise;
    logic [IDX_W-1:0]   ptr_q;
    logic [NUM_CTR-1:0] busy;
    logic [NUM_CTR-1:0] start_vec;
    logic               refuse;

    dcp_edge_sync #(.STAGES(SYNC_STAGES)) u_err_sync (
        .clk(clk), .rst_n(rst_n), .din(err_in), .rise_o(err_rise));

    dcp_edge_sync #(.STAGES(SYNC_STAGES)) u_enc_sync (
        .clk(clk), .rst_n(rst_n), .din(enc_in), .rise_o(enc_rise));

    // An error edge is refused when the slot under the pointer still runs.
    always_comb refuse = err_rise & busy[ptr_q];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CTR; gi++) begin : g_slot
            // The pointed slot starts on an accepted error edge.
            always_comb start_vec[gi] = err_rise && !busy[gi] && (ptr_q == IDX_W'(gi));

            dcp_slot #(.CNT_W(CNT_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .start_i    (start_vec[gi]),
                .enc_pulse_i(enc_rise),
                .target_i   (dist_target),
                .busy_o     (busy[gi])
            );
        end
    endgenerate

    // Advance the rotating pointer on acceptance; latch overflow on refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            overflow <= 1'b0;
        end else if (err_rise) begin
            if (refuse)
                overflow <= 1'b1;
            else
                ptr_q <= IDX_W'(dcp_pkg::ring_next(32'(ptr_q), NUM_CTR));
        end
    end

    // The gate follows the union of all running slots.
    always_comb gate_en = |busy;

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_vec)); // R5
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < IDX_W'(NUM_CTR)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R6
    AST_PTR_HOLD_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> $stable(ptr_q)); // R6
    AST_GATE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_vec) |=> gate_en); // R7
endmodule

// File: tb/tb_dist_counter_pool.sv
`timescale 1ns/1ps
module tb_dist_counter_pool;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_in = 1'b0;
    logic        enc_in = 1'b0;
    logic [15:0] dist_target = '0;
    wire         gate_en;
    wire         overflow;

    int applied = 0;
    int misses  = 0;
    bit done    = 0;

    always #4 clk = ~clk; // 125 MHz

    dist_counter_pool dut (
        .clk(clk), .rst_n(rst_n), .err_in(err_in), .enc_in(enc_in),
        .dist_target(dist_target), .gate_en(gate_en), .overflow(overflow));

    typedef struct packed {
        logic [7:0] tgt;
        logic [7:0] nerr;
        logic [7:0] nenc;
        logic       gate;
        logic       ovf;
    } vec_t;

    // target, error events, encoder pulses, expected gate, expected overflow
    localparam vec_t VECS [8] = '{
        '{8'd5, 8'd1,  8'd3, 1'b1, 1'b0},
        '{8'd5, 8'd1,  8'd5, 1'b0, 1'b0},
        '{8'd3, 8'd10, 8'd2, 1'b1, 1'b0},
        '{8'd3, 8'd10, 8'd3, 1'b0, 1'b0},
        '{8'd4, 8'd11, 8'd0, 1'b1, 1'b1},
        '{8'd0, 8'd1,  8'd0, 1'b0, 1'b0},
        '{8'd2, 8'd0,  8'd4, 1'b0, 1'b0},
        '{8'd7, 8'd12, 8'd7, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; err_in = 1'b0; enc_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic err_pulse();
        @(negedge clk) err_in = 1'b1;
        repeat (3) @(negedge clk);
        err_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic enc_pulse();
        @(negedge clk) enc_in = 1'b1;
        repeat (3) @(negedge clk);
        enc_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        do_reset();
        #1;
        chk("R8 gate after reset", gate_en, 0);
        chk("R8 overflow after reset", overflow, 0);

        // Table walk: R1 R3 R4 R5 R6 R7
        foreach (VECS[i]) begin
            do_reset();
            dist_target = 16'(VECS[i].tgt);
            for (int e = 0; e < int'(VECS[i].nerr); e++) err_pulse();
            for (int p = 0; p < int'(VECS[i].nenc); p++) enc_pulse();
            repeat (6) @(negedge clk);
            chk($sformatf("R7 gate row %0d", i), gate_en, VECS[i].gate);
            chk($sformatf("R6 overflow row %0d", i), overflow, VECS[i].ovf);
        end

        // R2: start latency through the synchronizers
        do_reset();
        dist_target = 16'd5;
        @(negedge clk) err_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R2 gate before third edge", gate_en, 0);
        @(posedge clk); #1;
        chk("R2 gate after third edge", gate_en, 1);
        // R2: a held level starts a single counter
        repeat (30) @(negedge clk);
        chk("R2 held level no overflow", overflow, 0);
        err_in = 1'b0;
        for (int p = 0; p < 5; p++) enc_pulse();
        repeat (4) @(negedge clk);
        chk("R2 single window finished", gate_en, 0);

        // R4: stop edge timing with target 1
        do_reset();
        dist_target = 16'd1;
        err_pulse();
        @(negedge clk) enc_in = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); #1;
        chk("R4 still running at count edge", gate_en, 1);
        @(posedge clk); #1;
        chk("R4 stopped one edge later", gate_en, 0);
        @(negedge clk) enc_in = 1'b0;

        // R1: overlapping windows end on their own counts
        do_reset();
        dist_target = 16'd3;
        err_pulse();
        enc_pulse(); enc_pulse();
        err_pulse();
        enc_pulse();
        repeat (3) @(negedge clk);
        chk("R1 second window still open", gate_en, 1);
        enc_pulse(); enc_pulse();
        repeat (3) @(negedge clk);
        chk("R1 both windows closed", gate_en, 0);

        // R3: encoder edges while idle do nothing
        do_reset();
        dist_target = 16'd2;
        enc_pulse(); enc_pulse(); enc_pulse();
        err_pulse();
        enc_pulse();
        repeat (3) @(negedge clk);
        chk("R3 idle edges not counted", gate_en, 1);

        // R5: wrap and reuse of freed counters
        do_reset();
        dist_target = 16'd1;
        for (int e = 0; e < 10; e++) err_pulse();
        enc_pulse();
        repeat (3) @(negedge clk);
        chk("R5 pool drained", gate_en, 0);
        for (int e = 0; e < 10; e++) err_pulse();
        chk("R5 reuse accepted", overflow, 0);
        chk("R5 refilled pool runs", gate_en, 1);
        err_pulse();
        chk("R6 eleventh event refused", overflow, 1);

        // R6: sticky after the pool drains; R8: reset clears
        enc_pulse();
        repeat (3) @(negedge clk);
        chk("R6 overflow sticky", overflow, 1);
        err_pulse();
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R8 reset clears gate", gate_en, 0);
        chk("R8 reset clears overflow", overflow, 0);
        @(negedge clk) rst_n = 1'b1;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end
endmodule